// File: doc/BRIEF.md
# Timer Interrupt Flag Unit

This block keeps the four event flags of a 16-bit timer/counter: overflow, compare channel A, compare channel B and input capture. It watches the running count, both compare values, the capture/TOP value, a capture strobe, an overflow strobe, the forced-compare strobes and the 4-bit waveform mode code. From these it decides on each clock whether a flag becomes set. The flags are presented as one 8-bit status byte that software reads over a plain write/read bus.

Software clears a flag by writing a one to its bit. The interrupt controller clears a flag by pulsing the matching acknowledge line. Each flag also drives an interrupt request through its own enable. The timer clock is a clock-enable input named `tick`. The compare path samples and advances only on cycles where `tick` is high, so a compare flag appears one timer tick after the count matched. The counter, the waveform outputs and the pin logic sit outside this block. There is no streamed data at the edge of the block, so every pin is plain control or status with no handshake.

Top module: `tmr_irq_flags`

## Requirements
- R1: The status byte `rd_data` holds the overflow flag at bit 0, compare A at bit 1, compare B at bit 2 and capture at bit 5. Bits 3, 4, 6 and 7 always read 0, and writing ones to them changes nothing.
- R2: While `rst_n` is low, all four flags and all `irq` outputs are 0.
- R3: When the mode is not 8, 10, 12 or 14, a high `cap_evt` sets the capture flag at the next clock edge, whatever the level of `tick`.
- R4: In modes 8, 10, 12 and 14 the capture register acts as TOP and `cap_evt` is ignored. The capture flag is then set on an enabled tick when the previous enabled tick saw `cnt == cap_top`.
- R5: Compare flag A (or B) is set on the enabled tick that follows the enabled tick in which `cnt` equalled `cmp_a` (or `cmp_b`). It is never set in the matching tick itself. Cycles with `tick` low neither sample the count nor advance this delay.
- R6: A pulse on `frc_a` or `frc_b` never sets any flag.
- R7: A high `ovf_evt` sets the overflow flag at the next clock edge.
- R8: Writing with `wr_en` high clears every flag whose bit in `wr_data` is 1. Flags whose bit is 0 keep their value.
- R9: A high `ack[i]` clears flag i at the next edge. The index map is 0 overflow, 1 compare A, 2 compare B, 3 capture.
- R10: If a flag's set condition and a clear from a write or an acknowledge land in the same cycle, the flag ends up set.
- R11: `irq[i]` is high exactly when flag i is set and `ien[i]` is high, using the index map of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and flag clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| cnt | input | CNT_W | Current counter value |
| cmp_a | input | CNT_W | Compare value, channel A |
| cmp_b | input | CNT_W | Compare value, channel B |
| cap_top | input | CNT_W | Capture register, also TOP in some modes |
| cap_evt | input | 1 | Capture event strobe |
| ovf_evt | input | 1 | Counter overflow strobe |
| frc_a | input | 1 | Forced-compare strobe, channel A |
| frc_b | input | 1 | Forced-compare strobe, channel B |
| wmode | input | 4 | Waveform mode code |
| wr_en | input | 1 | Status byte write strobe |
| wr_data | input | 8 | Write data; ones clear flags |
| rd_data | output | 8 | Status byte |
| ack | input | 4 | Per-flag interrupt acknowledge pulses |
| ien | input | 4 | Per-flag interrupt enables |
| irq | output | 4 | Per-flag interrupt requests |

## Verification
A flag's set condition and its clear can occur in the same cycle. The clear comes either from a write-one or from an acknowledge pulse. The bench provokes this on purpose: it raises `ack` or writes a one in the same cycle as a capture strobe, an overflow strobe or a pending compare that fires. It also runs a long random phase with small count and compare ranges, so these collisions recur under irregular ticks and mode changes. The flag is judged correct only if it reads as set afterwards, and a behavioural model compares every status bit and request on every clock.

// File: rtl/tif_pkg.sv
package tif_pkg;

  localparam int NFLAG  = 4;
  localparam int REG_W  = 8;

  localparam int FI_OVF = 0;
  localparam int FI_CA  = 1;
  localparam int FI_CB  = 2;
  localparam int FI_CAP = 3;

  localparam int NCMP   = 3;
  localparam int CI_A   = 0;
  localparam int CI_B   = 1;
  localparam int CI_TOP = 2;

  // status-byte position of each flag index
  function automatic int flag_pos(input int idx);
    case (idx)
      FI_OVF:  return 0;
      FI_CA:   return 1;
      FI_CB:   return 2;
      default: return 5;
    endcase
  endfunction

  // waveform modes in which the capture register is the counter's TOP
  function automatic logic cap_is_top(input logic [3:0] mode);
    case (mode)
      4'd8, 4'd10, 4'd12, 4'd14: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tif_match_stage.sv
module tif_match_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ref_val,
  output logic             fire
);
  logic hit_q;

  // equality is captured on one enabled tick and released on the next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hit_q <= 1'b0;
    else if (tick) hit_q <= (cnt == ref_val);
  end

  assign fire = tick & hit_q;
endmodule

// File: rtl/tif_flag_bit.sv
module tif_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/tif_regmap.sv
module tif_regmap
  import tif_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [NFLAG-1:0] clr_wr,
  output logic [REG_W-1:0] rd_data
);
  generate
    for (genvar g = 0; g < NFLAG; g++) begin : g_clr
      localparam int POS = flag_pos(g);
      assign clr_wr[g] = wr_en & wr_data[POS];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NFLAG; i++) rd_data[flag_pos(i)] = flags[i];
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[7:6], wr_data[4:3]};
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tif_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cap_top,
  input  logic             cap_evt,
  input  logic             ovf_evt,
  input  logic             frc_a,
  input  logic             frc_b,
  input  logic [3:0]       wmode,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [3:0]       ack,
  input  logic [3:0]       ien,
  output logic [3:0]       irq
);
  logic [NCMP-1:0][CNT_W-1:0] refs;
  logic [NCMP-1:0]            fire;
  logic [NFLAG-1:0]           set_v;
  logic [NFLAG-1:0]           clr_wr;
  logic [NFLAG-1:0]           clr_v;
  logic [NFLAG-1:0]           flags;
  logic                       top_mode;

  assign refs[CI_A]   = cmp_a;
  assign refs[CI_B]   = cmp_b;
  assign refs[CI_TOP] = cap_top;

  generate
    for (genvar c = 0; c < NCMP; c++) begin : g_cmp
      tif_match_stage #(.CNT_W(CNT_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt     (cnt),
        .ref_val (refs[c]),
        .fire    (fire[c])
      );
    end
  endgenerate

  assign top_mode = cap_is_top(wmode);

  // set sources; forced-compare strobes deliberately feed none of them
  assign set_v[FI_OVF] = ovf_evt;
  assign set_v[FI_CA]  = fire[CI_A];
  assign set_v[FI_CB]  = fire[CI_B];
  assign set_v[FI_CAP] = top_mode ? fire[CI_TOP] : cap_evt;

  tif_regmap u_map (
    .flags   (flags),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr_wr  (clr_wr),
    .rd_data (rd_data)
  );

  assign clr_v = clr_wr | ack;

  generate
    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      tif_flag_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v[f]),
        .clr_i  (clr_v[f]),
        .flag_o (flags[f])
      );
    end
  endgenerate

  assign irq = flags & ien;

  logic unused_force;
  assign unused_force = frc_a | frc_b;
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cap_evt,
  input logic       ovf_evt,
  input logic [3:0] wmode,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [3:0] ack,
  input logic [7:0] rd_data
);
  logic topm;
  assign topm = (wmode == 4'd8) || (wmode == 4'd10) || (wmode == 4'd12) || (wmode == 4'd14);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00 && rd_data[4:3] == 2'b00);

  p_cap_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && !topm |=> rd_data[5]);

  p_top_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[5]) && $past(topm) |-> $past(tick));

  p_cmpa_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[1]) |-> $past(tick));

  p_cmpb_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> $past(tick));

  p_ovf_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> rd_data[0]);

  p_zero_write_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[0] && !ack[0] |=> !$fell(rd_data[0]));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack[0] && !ovf_evt |=> !rd_data[0]);

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && !topm && (ack[3] || (wr_en && wr_data[5])) |=> rd_data[5]);
endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .cap_evt (cap_evt),
  .ovf_evt (ovf_evt),
  .wmode   (wmode),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .ack     (ack),
  .rd_data (rd_data)
);

// File: tb/tmr_irq_flags_bench.sv
`timescale 1ns/1ps
module tmr_irq_flags_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] cnt = '0, cmp_a = 16'h0100, cmp_b = 16'h0200, cap_top = 16'h0300;
  logic         cap_evt = 1'b0, ovf_evt = 1'b0, frc_a = 1'b0, frc_b = 1'b0;
  logic [3:0]   wmode = 4'd0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = '0;
  logic [7:0]   rd_data;
  logic [3:0]   ack = '0, ien = '0;
  logic [3:0]   irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R2";
  bit done = 0;

  always #5 clk = ~clk;

  tmr_irq_flags #(.CNT_W(W)) u_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cap_top(cap_top), .cap_evt(cap_evt), .ovf_evt(ovf_evt), .frc_a(frc_a), .frc_b(frc_b),
    .wmode(wmode), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ack(ack), .ien(ien), .irq(irq)
  );

  // behavioural reference: flags indexed 0 ovf, 1 A, 2 B, 3 capture
  bit m_flag [4];
  bit m_seen_a, m_seen_b, m_seen_t;

  function automatic logic [7:0] m_byte();
    return {2'b00, m_flag[3], 2'b00, m_flag[2], m_flag[1], m_flag[0]};
  endfunction

  function automatic logic [3:0] m_irq();
    return {m_flag[3] & ien[3], m_flag[2] & ien[2], m_flag[1] & ien[1], m_flag[0] & ien[0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[i]) m_flag[i] = 0;
      m_seen_a = 0; m_seen_b = 0; m_seen_t = 0;
    end else begin
      bit s [4];
      bit c [4];
      bit is_top;
      is_top = (wmode inside {4'd8, 4'd10, 4'd12, 4'd14});
      s[0] = ovf_evt;
      s[1] = tick && m_seen_a;
      s[2] = tick && m_seen_b;
      s[3] = is_top ? (tick && m_seen_t) : cap_evt;
      c[0] = ack[0] || (wr_en && wr_data[0]);
      c[1] = ack[1] || (wr_en && wr_data[1]);
      c[2] = ack[2] || (wr_en && wr_data[2]);
      c[3] = ack[3] || (wr_en && wr_data[5]);
      if (tick) begin
        m_seen_a = (cnt == cmp_a);
        m_seen_b = (cnt == cmp_b);
        m_seen_t = (cnt == cap_top);
      end
      for (int i = 0; i < 4; i++) begin
        if (s[i]) m_flag[i] = 1;
        else if (c[i]) m_flag[i] = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(cur_req, rd_data, m_byte());
    chk("R11", {4'h0, irq}, {4'h0, m_irq()});
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cap_evt = 0; ovf_evt = 0; frc_a = 0; frc_b = 0; wr_en = 0; wr_data = '0; ack = '0;
  endtask

  initial begin
    #5000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R2", rd_data, 8'h00);
    chk("R2", {4'h0, irq}, 8'h00);
    rst_n = 1; cyc(1);

    // R1: writes to reserved bits change nothing
    cur_req = "R1";
    wr_en = 1; wr_data = 8'hD8; cyc(1); idle(); cyc(1);
    chk("R1", rd_data, 8'h00);

    // R3: capture strobe without tick
    cur_req = "R3";
    tick = 0; cap_evt = 1; cyc(1); idle(); cyc(1);
    chk("R3", rd_data, 8'h20);

    // R8: write zero keeps, write one clears
    cur_req = "R8";
    wr_en = 1; wr_data = 8'h00; cyc(1); idle();
    chk("R8", rd_data, 8'h20);
    wr_en = 1; wr_data = 8'h20; cyc(1); idle();
    chk("R8", rd_data, 8'h00);

    // R5: compare A timing with tick every cycle
    cur_req = "R5";
    tick = 1; cnt = cmp_a; cyc(1); cnt = 16'h0001;
    chk("R5", rd_data, 8'h00);
    cyc(1);
    chk("R5", rd_data, 8'h02);
    wr_en = 1; wr_data = 8'h02; cyc(1); idle();

    // R5: sparse ticks, compare B
    tick = 1; cnt = cmp_b; cyc(1); tick = 0; cnt = 16'h0002; cyc(3);
    chk("R5", rd_data, 8'h00);
    tick = 1; cyc(1); tick = 0;
    chk("R5", rd_data, 8'h04);
    wr_en = 1; wr_data = 8'h04; cyc(1); idle();

    // R6: forced strobes alone
    cur_req = "R6";
    tick = 1; cnt = 16'h0005; frc_a = 1; frc_b = 1; cyc(3); idle(); cyc(2);
    chk("R6", rd_data, 8'h00);

    // R7 then R9
    cur_req = "R7";
    ovf_evt = 1; cyc(1); idle();
    chk("R7", rd_data, 8'h01);
    cur_req = "R9";
    ack = 4'b0001; cyc(1); idle();
    chk("R9", rd_data, 8'h00);

    // R10: set and clear collide
    cur_req = "R10";
    ovf_evt = 1; ack = 4'b0001; cyc(1); idle();
    chk("R10", rd_data, 8'h01);
    cap_evt = 1; wr_en = 1; wr_data = 8'h21; cyc(1); idle();
    chk("R10", rd_data, 8'h20);
    cnt = cmp_a; cyc(1); cnt = 16'h0007; ack = 4'b0010; cyc(1); idle();
    chk("R10", rd_data, 8'h22);
    wr_en = 1; wr_data = 8'hFF; cyc(1); idle();

    // R4: capture register as TOP
    cur_req = "R4";
    wmode = 4'd12; cap_evt = 1; cyc(2); idle();
    chk("R4", rd_data, 8'h00);
    cnt = cap_top; cyc(1); cnt = 16'h0008;
    chk("R4", rd_data, 8'h00);
    cyc(1);
    chk("R4", rd_data, 8'h20);

    // R11: requests follow enables
    cur_req = "R11";
    ien = 4'b1000; #1;
    chk("R11", {4'h0, irq}, 8'h08);
    ien = 4'b0111; #1;
    chk("R11", {4'h0, irq}, 8'h00);
    wmode = 4'd0; wr_en = 1; wr_data = 8'hFF; cyc(1); idle();

    // random phase with small value ranges to force collisions
    cur_req = "R10";
    cmp_a = 16'd3; cmp_b = 16'd5; cap_top = 16'd6;
    for (int k = 0; k < 4000; k++) begin
      int mc;
      tick    = ($urandom_range(0, 2) != 0);
      cnt     = 16'($urandom_range(0, 7));
      cap_evt = ($urandom_range(0, 7) == 0);
      ovf_evt = ($urandom_range(0, 7) == 0);
      frc_a   = ($urandom_range(0, 5) == 0);
      frc_b   = ($urandom_range(0, 5) == 0);
      wr_en   = ($urandom_range(0, 5) == 0);
      wr_data = 8'($urandom());
      ack     = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'h0;
      ien     = 4'($urandom());
      mc      = $urandom_range(0, 9);
      if (mc == 0) wmode = 4'd12;
      else if (mc == 1) wmode = 4'd8;
      else if (mc == 2) wmode = 4'd4;
      else if (mc == 3) wmode = 4'd0;
      cyc(1);
    end
    idle(); cyc(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule